// File: doc/BRIEF.md
# Automatic Frequency Correction Controller

This block is the digital control logic that sits between a frequency-error measurement engine and the PLL of a radio receiver. The engine delivers signed 8-bit frequency-error samples on a bus, each marked by a one-clock valid pulse. The controller groups these samples into measurement cycles of fixed length. The last sample seen in a cycle becomes that cycle's result. The controller keeps an offset register and, when asked, adds that register to the 16-bit PLL frequency control word passing through it.

The offset register can be loaded in three ways:
- by hand, on a rising edge of the strobe input;
- once after reset, by automatic capture;
- repeatedly, by automatic capture whenever two consecutive equal results arrive in a cycle during which the signal-present indicator never dropped.

In the repeated mode, losing the signal-present indicator clears the offset.

The controller also reports three status bits:
- a lock flag;
- an equal-results flag;
- a toggle that flips on every completed measurement cycle.

Top module: `afc_ctrl`

## Requirements
- R1: When `corr_en` is 0, `fcw_out` equals `fcw_in`. When `corr_en` is 1, `fcw_out` equals `fcw_in` plus the sign-extended `offset`, modulo 2^16. Both outputs are combinational.
- R2: On the first clock where `strobe` is high after being low, `offset` takes the most recent sample accepted before that clock. Holding `strobe` high does not load it again.
- R3: While `calc_en` is 0, samples are ignored, the cycle counter stays cleared, and `toggle` and `same` keep their values.
- R4: A measurement cycle lasts CYC_LEN clocks with `calc_en` high when `fine` is 0, and 2*CYC_LEN clocks when `fine` is 1. `toggle` inverts at the end of each cycle.
- R5: At the end of each cycle, `same` becomes 1 if that cycle's result equals the previous cycle's result, and 0 otherwise. It is 0 after the first cycle following reset.
- R6: `auto_mode` 2'b00 never updates `offset` automatically.
- R7: In `auto_mode` 2'b10 and 2'b11, `offset` is loaded with the cycle's result at the end of a cycle that meets two conditions: `sig_ok` was high on every clock of the cycle, and the result equals the previous result.
- R8: In `auto_mode` 2'b01, the first qualifying cycle after reset loads `offset`. After that, automatic updates stop, and a low `sig_ok` does not clear `offset`.
- R9: In `auto_mode` 2'b10 and 2'b11, any clock with `sig_ok` low clears `offset` to 0 at the next edge. This clear takes priority over a strobe edge.
- R10: `lock` is 1 exactly when three things hold: `offset` has been loaded since it was last cleared or reset, at least one cycle result exists, and the latest result equals `offset`.
- R11: After reset, `offset`, `lock`, `same` and `toggle` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_in | input | 8 | Signed frequency-error sample |
| err_vld | input | 1 | Sample valid pulse |
| sig_ok | input | 1 | Signal-present indicator |
| strobe | input | 1 | Manual offset load, rising-edge active |
| fine | input | 1 | Doubles the measurement cycle length |
| corr_en | input | 1 | Adds offset to control word |
| calc_en | input | 1 | Enables error measurement |
| auto_mode | input | 2 | Automatic update mode |
| fcw_in | input | 16 | PLL control word in |
| fcw_out | output | 16 | Corrected PLL control word |
| offset | output | 8 | Offset register |
| lock | output | 1 | Loop locked |
| same | output | 1 | Last two results equal |
| toggle | output | 1 | Flips each measurement cycle |

## Verification
The hardest situation to reach from the ports is a cycle whose result repeats the previous one but which still must not load, because `sig_ok` dipped for a single clock in the middle of it. In the clearing modes, the dip also wipes the offset, which hides the effect. The stimulus therefore uses the one-shot mode, where no clear happens, and drives two equal results with a one-clock dip in the second cycle. It then checks that the offset stays 0 until a third, clean cycle loads it. Cycle boundaries are aligned by dropping `calc_en` for one clock before each scenario.

// File: rtl/afc_ctrl.sv
module afc_ctrl #(
  parameter int ERR_W   = 8,
  parameter int FCW_W   = 16,
  parameter int CYC_LEN = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ERR_W-1:0] err_in,
  input  logic             err_vld,
  input  logic             sig_ok,
  input  logic             strobe,
  input  logic             fine,
  input  logic             corr_en,
  input  logic             calc_en,
  input  logic [1:0]       auto_mode,
  input  logic [FCW_W-1:0] fcw_in,
  output logic [FCW_W-1:0] fcw_out,
  output logic [ERR_W-1:0] offset,
  output logic             lock,
  output logic             same,
  output logic             toggle
);
  localparam int CNT_W = $clog2(2 * CYC_LEN);

  logic [CNT_W-1:0] cnt, cyc_last;
  logic [ERR_W-1:0] smp, smp_nx, res;
  logic res_ok, loaded, once_done, st_q, vdi_run;
  logic cyc_end, match, st_rise, loss, auto_hit, auto_allow;

  assign cyc_last   = fine ? CNT_W'(2 * CYC_LEN - 1) : CNT_W'(CYC_LEN - 1);
  assign smp_nx     = (calc_en && err_vld) ? err_in : smp;
  assign cyc_end    = calc_en && (cnt >= cyc_last);
  assign match      = res_ok && (smp_nx == res);
  assign st_rise    = strobe && !st_q;
  assign loss       = auto_mode[1] && !sig_ok;
  assign auto_allow = auto_mode[1] || (auto_mode == 2'b01 && !once_done);
  assign auto_hit   = cyc_end && vdi_run && sig_ok && match && auto_allow;

  assign fcw_out = corr_en ? fcw_in + {{(FCW_W-ERR_W){offset[ERR_W-1]}}, offset} : fcw_in;
  assign lock    = loaded && res_ok && (res == offset);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      smp       <= '0;
      res       <= '0;
      res_ok    <= 1'b0;
      same      <= 1'b0;
      toggle    <= 1'b0;
      vdi_run   <= 1'b1;
      st_q      <= 1'b0;
      offset    <= '0;
      loaded    <= 1'b0;
      once_done <= 1'b0;
    end else begin
      st_q <= strobe;
      smp  <= smp_nx;
      if (!calc_en) begin
        cnt     <= '0;
        vdi_run <= 1'b1;
      end else if (cyc_end) begin
        cnt     <= '0;
        vdi_run <= 1'b1;
        res     <= smp_nx;
        res_ok  <= 1'b1;
        same    <= match;
        toggle  <= ~toggle;
      end else begin
        cnt     <= cnt + 1'b1;
        vdi_run <= vdi_run & sig_ok;
      end
      if (loss) begin
        offset <= '0;
        loaded <= 1'b0;
      end else if (st_rise) begin
        offset <= smp;
        loaded <= 1'b1;
      end else if (auto_hit) begin
        offset <= smp_nx;
        loaded <= 1'b1;
        if (!auto_mode[1]) once_done <= 1'b1;
      end
    end
  end

  AST_STROBE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_rise && !loss) |=> offset == $past(smp)); // R2
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !calc_en |=> ($stable(toggle) && $stable(same))); // R3
  AST_NO_AUTO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_mode == 2'b00 && !st_rise) |=> $stable(offset)); // R6
  AST_ONCE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_mode == 2'b01 && once_done && !st_rise) |=> $stable(offset)); // R8
  AST_CLEAR_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    loss |=> (offset == '0 && !lock)); // R9
  AST_LOCK_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
    lock |-> (loaded && res_ok)); // R10
  AST_SAME_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(same) |-> toggle != $past(toggle)); // R5
endmodule

// File: tb/test_afc_ctrl.sv
module test_afc_ctrl;
  localparam int N = 8;
  logic clk = 0, rst_n = 0;
  logic [7:0] err_in = 0;
  logic err_vld = 0, sig_ok = 1, strobe = 0, fine = 0, corr_en = 0, calc_en = 0;
  logic [1:0] auto_mode = 0;
  logic [15:0] fcw_in = 0, fcw_out;
  logic [7:0] offset;
  logic lock, same, toggle;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  afc_ctrl i_afc_ctrl (.clk, .rst_n, .err_in, .err_vld, .sig_ok, .strobe, .fine,
    .corr_en, .calc_en, .auto_mode, .fcw_in, .fcw_out, .offset, .lock, .same, .toggle);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 0; err_in = 0; err_vld = 0; sig_ok = 1; strobe = 0; fine = 0;
    corr_en = 0; calc_en = 0; auto_mode = 0; fcw_in = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic idle();
    calc_en = 0; err_vld = 0;
    @(negedge clk);
  endtask

  task automatic run_cyc(logic [7:0] v, bit dip);
    calc_en = 1; err_vld = 1; err_in = v;
    for (int i = 0; i < N; i++) begin
      sig_ok = !(dip && i == N / 2);
      @(negedge clk);
    end
    sig_ok = 1; err_vld = 0;
  endtask

  task automatic t_reset();
    do_reset();
    corr_en = 1; fcw_in = 16'hABCD; #1;
    chk("R11 offset", offset, 0);
    chk("R11 lock", lock, 0);
    chk("R11 same", same, 0);
    chk("R11 toggle", toggle, 0);
    chk("R1 zero offset", fcw_out, 16'hABCD);
  endtask

  task automatic t_strobe_fcw();
    do_reset();
    calc_en = 1; err_vld = 1; err_in = 8'hFB;
    @(negedge clk); err_vld = 0; strobe = 1;
    @(negedge clk);
    chk("R2 load", offset, 8'hFB);
    err_vld = 1; err_in = 8'h10;
    @(negedge clk); err_vld = 0;
    @(negedge clk);
    chk("R2 held high no reload", offset, 8'hFB);
    strobe = 0; @(negedge clk); strobe = 1; @(negedge clk); strobe = 0;
    chk("R2 second edge", offset, 8'h10);
    fcw_in = 16'h1234; corr_en = 0; #1;
    chk("R1 pass", fcw_out, 16'h1234);
    corr_en = 1; #1;
    chk("R1 add", fcw_out, 16'h1244);
    err_vld = 1; err_in = 8'hFB;
    @(negedge clk); err_vld = 0; strobe = 1;
    @(negedge clk); strobe = 0;
    fcw_in = 16'h0002; #1;
    chk("R1 negative wrap", fcw_out, 16'hFFFD);
  endtask

  task automatic t_calc_off();
    logic tg, sm;
    do_reset();
    calc_en = 1; err_vld = 1; err_in = 8'h21;
    @(negedge clk);
    calc_en = 0; err_in = 8'h55;
    tg = toggle; sm = same;
    repeat (3 * N) @(negedge clk);
    chk("R3 toggle held", toggle, tg);
    chk("R3 same held", same, sm);
    strobe = 1; @(negedge clk); strobe = 0; err_vld = 0;
    chk("R3 sample ignored", offset, 8'h21);
  endtask

  task automatic t_cycles();
    do_reset(); idle();
    run_cyc(8'h03, 0);
    chk("R4 toggle first", toggle, 1);
    chk("R5 same first", same, 0);
    run_cyc(8'h03, 0);
    chk("R4 toggle second", toggle, 0);
    chk("R5 same equal", same, 1);
    chk("R6 no auto load", offset, 0);
    run_cyc(8'h04, 0);
    chk("R5 same differ", same, 0);
  endtask

  task automatic t_fine();
    do_reset(); fine = 1; idle();
    calc_en = 1; err_vld = 1; err_in = 8'h01;
    repeat (N) @(negedge clk);
    chk("R4 fine half", toggle, 0);
    repeat (N) @(negedge clk);
    chk("R4 fine full", toggle, 1);
  endtask

  task automatic t_mode10(logic [1:0] m);
    do_reset(); auto_mode = m; idle();
    run_cyc(8'h07, 0);
    chk("R7 one result", offset, 0);
    run_cyc(8'h07, 0);
    chk("R7 auto load", offset, 8'h07);
    chk("R10 lock set", lock, 1);
    run_cyc(8'h09, 0);
    chk("R10 lock drop", lock, 0);
    chk("R7 hold on change", offset, 8'h07);
    run_cyc(8'h09, 0);
    chk("R7 reload", offset, 8'h09);
    calc_en = 0; sig_ok = 0; strobe = 1;
    @(negedge clk); sig_ok = 1; strobe = 0;
    chk("R9 clear", offset, 0);
    chk("R9 lock cleared", lock, 0);
  endtask

  task automatic t_mode01();
    do_reset(); auto_mode = 2'b01; idle();
    run_cyc(8'h06, 0);
    run_cyc(8'h06, 1);
    chk("R7 dip blocks load", offset, 0);
    run_cyc(8'h06, 0);
    chk("R8 first load", offset, 8'h06);
    run_cyc(8'h08, 0);
    run_cyc(8'h08, 0);
    chk("R8 frozen", offset, 8'h06);
    calc_en = 0; sig_ok = 0;
    @(negedge clk); @(negedge clk); sig_ok = 1;
    chk("R8 no clear", offset, 8'h06);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_strobe_fcw();
    t_calc_off();
    t_cycles();
    t_fine();
    t_mode10(2'b10);
    t_mode10(2'b11);
    t_mode01();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule